// File: doc/BRIEF.md
# Dual-Domain Reset and Power-State Controller

This block governs reset and power for two converter domains on one die: a capture (ADC) domain and a playback (DAC) domain. Each domain owns an active-low power-down pin. While a domain's pin is low, its logic is held in reset and its configuration registers and power-enable bit are kept at their initial values. When the pin is high, software may program the domain's registers and switch its power on through a generic address/data write strobe. A shared negative-rail charge pump is enabled while at least one domain is powered.

A strap input selects hardware control. In that mode the power-enable bits no longer count, and each domain is powered exactly when its pin is high. Both pins pass through multi-flop synchronizers before any logic uses them, so the pins may change at any time with respect to the clock.

Top module: `dual_domain_pwr_ctl`

## Requirements
- R1: While and directly after `rst`, all configuration registers read their initial values (address 1: 0x11, address 2: 0x22, address 3: 0x33), both power-enable bits read 0, `adc_rst` and `dac_rst` are 1, and `adc_pwr_on`, `dac_pwr_on` and `cp_en` are 0.
- R2: A level on a power-down pin that is sampled at clock edge k is reflected in that domain's reset output after edge k+1, with `adc_rst`/`dac_rst` equal to the inverse of the synchronized pin. This applies to both falling and rising pin levels.
- R3: A synchronized low on `adc_pd_n` returns the registers at addresses 1 and 2 and the ADC power-enable bit (address 0, bit 0) to their initial values. The DAC register and the DAC power-enable bit are left unchanged.
- R4: A synchronized low on `dac_pd_n` returns the register at address 3 and the DAC power-enable bit (address 0, bit 1) to their initial values. The ADC registers and the ADC power-enable bit are left unchanged.
- R5: A write to a register that belongs to a domain in reset is discarded. Reads and configuration outputs of that domain's registers return the initial values. In an address-0 write, each bit is gated by its own domain's state.
- R6: In register mode (`hw_mode`=0), a domain is powered exactly when its synchronized pin is high and its power-enable bit is 1.
- R7: In hardware mode (`hw_mode`=1), a domain is powered exactly when its synchronized pin is high, whatever the value of its power-enable bit.
- R8: `cp_en` is 1 exactly when at least one domain is powered. With both synchronized pins low, `cp_en` is 0 and every register reads its initial value.
- R9: After a pin returns high, that domain stays unpowered in register mode until a 1 is written to its power-enable bit.
- R10: Register map: address 0 reads {zeros, DAC enable, ADC enable}, with upper bits 0. Addresses 1 and 2 are ADC configuration and address 3 is DAC configuration. Data is `DATA_W` bits wide (default 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_pd_n | input | 1 | ADC domain power-down pin, active low, asynchronous |
| dac_pd_n | input | 1 | DAC domain power-down pin, active low, asynchronous |
| hw_mode | input | 1 | 1 = pins alone decide power, 0 = register control |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | DATA_W | Read data (combinational) |
| adc_cfg0 | output | DATA_W | ADC configuration word at address 1 |
| adc_cfg1 | output | DATA_W | ADC configuration word at address 2 |
| dac_cfg | output | DATA_W | DAC configuration word at address 3 |
| adc_rst | output | 1 | Reset to the ADC domain logic, active high |
| dac_rst | output | 1 | Reset to the DAC domain logic, active high |
| adc_pwr_on | output | 1 | ADC domain power enable |
| dac_pwr_on | output | 1 | DAC domain power enable |
| cp_en | output | 1 | Charge-pump enable |

## Verification
The risky coincidence is a register write that lands on the same clock edge on which the target domain's synchronized pin falls or rises. In that case the clear must win over the write, and a write issued one cycle later must behave by the new state. The bench provokes this with random writes issued every other cycle while the pins toggle at random, plus directed writes placed exactly on the synchronizer's transition edge. Each cycle it judges the read port, the configuration outputs and the power outputs against a bench model of the two-stage pin delay and the per-domain clears.

// File: rtl/ddpc_pkg.sv
package ddpc_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_POWER = 2'd0,
        RA_ADC0  = 2'd1,
        RA_ADC1  = 2'd2,
        RA_DAC   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic dac;
        logic adc;
    } dom_pair_t;

    function automatic logic dom_powered(input logic up, input logic hw, input logic en);
        return up & (hw | en);
    endfunction

endpackage

// File: rtl/ddpc_sync.sv
module ddpc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) q[0] <= 1'b0;
                    else     q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) q[i] <= 1'b0;
                    else     q[i] <= q[i-1];
                end
            end
        end
    endgenerate

    assign dout = q[STAGES-1];
endmodule

// File: rtl/ddpc_regfile.sv
module ddpc_regfile
    import ddpc_pkg::*;
#(
    parameter int              DATA_W    = 8,
    parameter logic [DATA_W-1:0] ADC0_INIT = DATA_W'(8'h11),
    parameter logic [DATA_W-1:0] ADC1_INIT = DATA_W'(8'h22),
    parameter logic [DATA_W-1:0] DAC_INIT  = DATA_W'(8'h33)
) (
    input  logic              clk,
    input  logic              rst,
    input  dom_pair_t         up,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output dom_pair_t         en,
    output logic [DATA_W-1:0] adc_cfg0,
    output logic [DATA_W-1:0] adc_cfg1,
    output logic [DATA_W-1:0] dac_cfg
);
    localparam int PAD_W = DATA_W - 2;

    logic [DATA_W-1:0] adc0_q, adc1_q, dac_q;
    dom_pair_t         en_q;
    reg_addr_e         waddr, raddr;

    assign waddr = reg_addr_e'(wr_addr);
    assign raddr = reg_addr_e'(rd_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            adc0_q <= ADC0_INIT;
            adc1_q <= ADC1_INIT;
            dac_q  <= DAC_INIT;
            en_q   <= '0;
        end else begin
            if (wr_en) begin
                unique case (waddr)
                    RA_POWER: begin
                        if (up.adc) en_q.adc <= wr_data[0];
                        if (up.dac) en_q.dac <= wr_data[1];
                    end
                    RA_ADC0: if (up.adc) adc0_q <= wr_data;
                    RA_ADC1: if (up.adc) adc1_q <= wr_data;
                    RA_DAC:  if (up.dac) dac_q  <= wr_data;
                    default: ;
                endcase
            end
            if (!up.adc) begin
                adc0_q   <= ADC0_INIT;
                adc1_q   <= ADC1_INIT;
                en_q.adc <= 1'b0;
            end
            if (!up.dac) begin
                dac_q    <= DAC_INIT;
                en_q.dac <= 1'b0;
            end
        end
    end

    // Visible values: a domain in reset always shows its initial state,
    // including the edge on which the clear is still pending.
    assign adc_cfg0 = up.adc ? adc0_q : ADC0_INIT;
    assign adc_cfg1 = up.adc ? adc1_q : ADC1_INIT;
    assign dac_cfg  = up.dac ? dac_q  : DAC_INIT;
    assign en.adc   = up.adc & en_q.adc;
    assign en.dac   = up.dac & en_q.dac;

    always_comb begin
        unique case (raddr)
            RA_POWER: rd_data = {{PAD_W{1'b0}}, en.dac, en.adc};
            RA_ADC0:  rd_data = adc_cfg0;
            RA_ADC1:  rd_data = adc_cfg1;
            RA_DAC:   rd_data = dac_cfg;
            default:  rd_data = '0;
        endcase
    end

    // R3: ADC domain storage returns to initial values after a synchronized low
    a_r3_adc_cleared: assert property (@(posedge clk) disable iff (rst)
        !up.adc |=> (adc0_q == ADC0_INIT && adc1_q == ADC1_INIT && !en_q.adc));

    // R4: DAC domain storage returns to initial values after a synchronized low
    a_r4_dac_cleared: assert property (@(posedge clk) disable iff (rst)
        !up.dac |=> (dac_q == DAC_INIT && !en_q.dac));

    // R4: DAC storage is untouched when only the ADC domain is held low
    a_r4_dac_kept: assert property (@(posedge clk) disable iff (rst)
        (up.dac && !(wr_en && waddr == RA_DAC)) |=> $stable(dac_q));

    // R5: a write to a domain in reset leaves its register at the initial value
    a_r5_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (!up.adc && wr_en && waddr == RA_ADC0) |=> (adc0_q == ADC0_INIT));
endmodule

// File: rtl/ddpc_power.sv
module ddpc_power
    import ddpc_pkg::*;
(
    input  dom_pair_t up,
    input  dom_pair_t en,
    input  logic      hw_mode,
    output dom_pair_t pwr,
    output dom_pair_t dom_rst,
    output logic      cp_en
);
    always_comb begin
        pwr.adc     = dom_powered(up.adc, hw_mode, en.adc);
        pwr.dac     = dom_powered(up.dac, hw_mode, en.dac);
        dom_rst.adc = ~up.adc;
        dom_rst.dac = ~up.dac;
        cp_en       = pwr.adc | pwr.dac;
    end
endmodule

// File: rtl/dual_domain_pwr_ctl.sv
module dual_domain_pwr_ctl
    import ddpc_pkg::*;
#(
    parameter int                DATA_W      = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] ADC0_INIT   = DATA_W'(8'h11),
    parameter logic [DATA_W-1:0] ADC1_INIT   = DATA_W'(8'h22),
    parameter logic [DATA_W-1:0] DAC_INIT    = DATA_W'(8'h33)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adc_pd_n,
    input  logic              dac_pd_n,
    input  logic              hw_mode,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] adc_cfg0,
    output logic [DATA_W-1:0] adc_cfg1,
    output logic [DATA_W-1:0] dac_cfg,
    output logic              adc_rst,
    output logic              dac_rst,
    output logic              adc_pwr_on,
    output logic              dac_pwr_on,
    output logic              cp_en
);
    localparam int NDOM = 2;

    dom_pair_t       up, en, pwr, drst;
    logic [NDOM-1:0] pins_n, synced;

    assign pins_n = {dac_pd_n, adc_pd_n};

    generate
        for (genvar d = 0; d < NDOM; d++) begin : g_dom_sync
            ddpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst  (rst),
                .din  (pins_n[d]),
                .dout (synced[d])
            );
        end
    endgenerate

    assign up = dom_pair_t'(synced);

    ddpc_regfile #(
        .DATA_W    (DATA_W),
        .ADC0_INIT (ADC0_INIT),
        .ADC1_INIT (ADC1_INIT),
        .DAC_INIT  (DAC_INIT)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .up       (up),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .en       (en),
        .adc_cfg0 (adc_cfg0),
        .adc_cfg1 (adc_cfg1),
        .dac_cfg  (dac_cfg)
    );

    ddpc_power u_power (
        .up      (up),
        .en      (en),
        .hw_mode (hw_mode),
        .pwr     (pwr),
        .dom_rst (drst),
        .cp_en   (cp_en)
    );

    assign adc_pwr_on = pwr.adc;
    assign dac_pwr_on = pwr.dac;
    assign adc_rst    = drst.adc;
    assign dac_rst    = drst.dac;

    // R2: a low pin sampled one edge earlier has reached the domain reset
    a_r2_adc_latency: assert property (@(posedge clk) disable iff (rst)
        $past(!adc_pd_n) |=> adc_rst);
    a_r2_dac_latency: assert property (@(posedge clk) disable iff (rst)
        $past(!dac_pd_n) |=> dac_rst);

    // R6: register mode with the enable bit clear keeps the domain off
    a_r6_bit_gates: assert property (@(posedge clk) disable iff (rst)
        (!hw_mode && !en.adc) |-> !adc_pwr_on);

    // R7: hardware mode powers a released domain regardless of its bit
    a_r7_hw_pin_rules: assert property (@(posedge clk) disable iff (rst)
        (hw_mode && up.dac) |-> dac_pwr_on);

    // R8: both domains held down keeps the charge pump off
    a_r8_pump_off: assert property (@(posedge clk) disable iff (rst)
        (!up.adc && !up.dac) |-> !cp_en);
endmodule

// File: tb/tb_dual_domain_pwr_ctl.sv
module tb_dual_domain_pwr_ctl;
    localparam int DW = 8;
    localparam logic [DW-1:0] I0 = 8'h11, I1 = 8'h22, I3 = 8'h33;

    logic clk = 0, rst = 1;
    logic adc_pd_n = 0, dac_pd_n = 0, hw_mode = 0, wr_en = 0;
    logic [1:0] wr_addr = 0, rd_addr = 0;
    logic [DW-1:0] wr_data = 0;
    logic [DW-1:0] rd_data, adc_cfg0, adc_cfg1, dac_cfg;
    logic adc_rst, dac_rst, adc_pwr_on, dac_pwr_on, cp_en;

    int n_cmp = 0, n_bad = 0;

    // model state
    logic m_s1a, m_s2a, m_s1d, m_s2d, m_ena, m_end;
    logic [DW-1:0] m_c0, m_c1, m_dc;

    always #5 clk = ~clk;

    dual_domain_pwr_ctl #(.DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .adc_pd_n(adc_pd_n), .dac_pd_n(dac_pd_n),
        .hw_mode(hw_mode), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .adc_cfg0(adc_cfg0),
        .adc_cfg1(adc_cfg1), .dac_cfg(dac_cfg), .adc_rst(adc_rst),
        .dac_rst(dac_rst), .adc_pwr_on(adc_pwr_on), .dac_pwr_on(dac_pwr_on),
        .cp_en(cp_en)
    );

    function automatic logic [DW-1:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:    return {6'd0, m_s2d & m_end, m_s2a & m_ena};
            2'd1:    return m_s2a ? m_c0 : I0;
            2'd2:    return m_s2a ? m_c1 : I1;
            default: return m_s2d ? m_dc : I3;
        endcase
    endfunction

    function automatic logic exp_pwr(input logic s2, input logic en);
        return s2 & (hw_mode | en);
    endfunction

    task automatic check(input logic ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            m_s1a = 0; m_s2a = 0; m_s1d = 0; m_s2d = 0;
            m_ena = 0; m_end = 0; m_c0 = I0; m_c1 = I1; m_dc = I3;
        end else begin
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin
                        if (m_s2a) m_ena = wr_data[0];
                        if (m_s2d) m_end = wr_data[1];
                    end
                    2'd1: if (m_s2a) m_c0 = wr_data;
                    2'd2: if (m_s2a) m_c1 = wr_data;
                    default: if (m_s2d) m_dc = wr_data;
                endcase
            end
            if (!m_s2a) begin m_c0 = I0; m_c1 = I1; m_ena = 0; end
            if (!m_s2d) begin m_dc = I3; m_end = 0; end
            m_s2a = m_s1a; m_s1a = adc_pd_n;
            m_s2d = m_s1d; m_s1d = dac_pd_n;
        end
    endtask

    task automatic check_all();
        logic [DW-1:0] e;
        e = exp_rd(rd_addr);
        check(rd_data === e, "R5/R10 rd_data", rd_data, e);
        check(adc_cfg0 === exp_rd(2'd1) && adc_cfg1 === exp_rd(2'd2), "R3 adc cfg",
              adc_cfg0, exp_rd(2'd1));
        check(dac_cfg === exp_rd(2'd3), "R4 dac cfg", dac_cfg, exp_rd(2'd3));
        check(adc_rst === !m_s2a && dac_rst === !m_s2d, "R2 domain reset",
              {6'd0, dac_rst, adc_rst}, {6'd0, !m_s2d, !m_s2a});
        check(adc_pwr_on === exp_pwr(m_s2a, m_ena) && dac_pwr_on === exp_pwr(m_s2d, m_end),
              hw_mode ? "R7 power" : "R6 power", {6'd0, dac_pwr_on, adc_pwr_on},
              {6'd0, exp_pwr(m_s2d, m_end), exp_pwr(m_s2a, m_ena)});
        check(cp_en === (exp_pwr(m_s2a, m_ena) | exp_pwr(m_s2d, m_end)), "R8 cp_en",
              {7'd0, cp_en}, {7'd0, exp_pwr(m_s2a, m_ena) | exp_pwr(m_s2d, m_end)});
    endtask

    // one clock: inputs already driven; model follows the edge; check at negedge
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all();
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    initial begin
        #2_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0A17));
        @(negedge clk);
        tick(); tick();
        // R1: reset state
        check(rd_data === 8'h00 && adc_rst && dac_rst && !cp_en, "R1 reset state",
              rd_data, 8'h00);
        rst = 0;
        rd_addr = 2'd3; tick();
        check(dac_cfg === I3 && adc_cfg0 === I0 && adc_cfg1 === I1, "R1 init values",
              dac_cfg, I3);
        // R5: writes with both pins low are dropped; R8 pump off
        wr(2'd1, 8'hA5); wr(2'd0, 8'h03);
        rd_addr = 2'd1; tick();
        check(rd_data === I0 && !cp_en, "R5 dropped write", rd_data, I0);
        // release both pins; R2 latency exactly two edges
        adc_pd_n = 1; dac_pd_n = 1;
        tick();
        check(adc_rst === 1'b1, "R2 one edge still reset", {7'd0, adc_rst}, 8'd1);
        tick();
        check(adc_rst === 1'b0 && dac_rst === 1'b0, "R2 released", {7'd0, adc_rst}, 8'd0);
        // R9: released but not powered
        check(!adc_pwr_on && !dac_pwr_on && !cp_en, "R9 stays off", {7'd0, cp_en}, 8'd0);
        wr(2'd1, 8'h5A); wr(2'd2, 8'hC3); wr(2'd3, 8'h7E); wr(2'd0, 8'hFF);
        rd_addr = 2'd0; tick();
        check(rd_data === 8'h03 && adc_pwr_on && dac_pwr_on && cp_en, "R10 power reg",
              rd_data, 8'h03);
        // R3: ADC pin low clears ADC side only
        adc_pd_n = 0; tick(); tick();
        rd_addr = 2'd3; tick();
        check(rd_data === 8'h7E && dac_pwr_on && cp_en, "R3 dac untouched", rd_data, 8'h7E);
        check(adc_cfg0 === I0 && adc_cfg1 === I1 && !adc_pwr_on, "R3 adc cleared",
              adc_cfg0, I0);
        // R7: hardware mode powers on the pin alone
        adc_pd_n = 1; tick(); tick();
        check(!adc_pwr_on, "R9 adc off after release", {7'd0, adc_pwr_on}, 8'd0);
        hw_mode = 1; tick();
        check(adc_pwr_on === 1'b1, "R7 hw on", {7'd0, adc_pwr_on}, 8'd1);
        hw_mode = 0;
        // R4: DAC pin low, with a write placed on the synchronizer's falling edge
        wr(2'd1, 8'h99);
        dac_pd_n = 0; tick();
        wr(2'd3, 8'h44);
        tick();
        check(dac_cfg === I3 && !dac_pwr_on && adc_cfg0 === 8'h99, "R4 dac cleared",
              dac_cfg, I3);
        // R8: both pins low
        adc_pd_n = 0; tick(); tick();
        check(!cp_en && adc_cfg0 === I0, "R8 all down", {7'd0, cp_en}, 8'd0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 15) == 0) adc_pd_n = ~adc_pd_n;
            if ($urandom_range(0, 15) == 0) dac_pd_n = ~dac_pd_n;
            if ($urandom_range(0, 63) == 0) hw_mode = ~hw_mode;
            wr_en   = (i % 2 == 0) ? 1'($urandom_range(0, 1)) : 1'b0;
            wr_addr = 2'($urandom_range(0, 3));
            wr_data = 8'($urandom);
            rd_addr = 2'($urandom_range(0, 3));
            tick();
        end
        wr_en = 0;
        // reset mid-run returns to R1 state
        rst = 1; tick();
        check(rd_data === exp_rd(rd_addr) && adc_rst && dac_rst && !cp_en, "R1 re-reset",
              rd_data, exp_rd(rd_addr));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule